// File: doc/BRIEF.md
# Smart Card Character Transmitter with Automatic Retransmit

This block sends characters over a single shared wire to a smart card style receiver. Each character goes out as a frame. The frame holds a start bit, eight data bits and an even parity bit. The block only ever pulls the wire low. A logic 1 is sent by releasing the wire, so an external pull-up and the far end can both act on it. After the parity bit, the block waits one and a half bit times and then looks at the wire. If the receiver is holding the wire low at that moment, it has rejected the character. The block then records an error-signal flag, leaves the transmit-end flag clear, waits a two-bit guard time and sends the same character again from its holding register. Software does nothing during this.

Software drives the block through a small register port with four registers: the character holding register, a control register, a status register and a retry limit. Bit timing comes from a `half_tick` strobe that pulses twice per bit period. A retry limit caps the automatic resends. When a character is rejected again after the last allowed resend, the block gives up. It sets a retry-overflow flag and the transmit-end flag, so that software can recover. The transmit and receive enables are guarded. A control write that would set both, or that would swap direction without first clearing the active one, is discarded unless self-test is requested. The wire stays released unless smart card mode and transmit enable are both on.

Top module: `sc_char_tx`

## Requirements
- R1: A frame starts on the first `half_tick` after a character is written while transmission is allowed. Each bit lasts two `half_tick` intervals. The bit order on the wire is: start bit (driven low), the 8 data bits least significant first, then a parity bit. The parity bit makes the count of ones across the data and parity bits on the wire even. A 1 is sent by releasing the wire (`line_oe`=0).
- R2: When the invert bit (control bit 4) is set, the data bits are inverted and sent most significant first. Parity stays even over the bits as they appear on the wire.
- R3: The wire is sampled on the third `half_tick` after the parity bit ends. If it is low, status bit 2 (error signal) is set and status bit 1 (transmit end) stays 0.
- R4: `irq_err` is high exactly while status bit 2 and control bit 5 (error interrupt enable) are both set.
- R5: After an error sample, and when the retry limit is not reached, the held character is sent again. The start bit of the resend begins on the fourth `half_tick` after the sample.
- R6: A frame whose sample finds the wire high sets status bit 1. `irq_end` equals status bit 1 AND control bit 6. Status bit 1 clears when a new character is taken from the holding register. Status bit 0 reads 1 while the holding register is empty.
- R7: If an error is sampled after the number of resends already equals the retry limit (address 3), no further resend occurs. Status bit 3 (retry overflow) and status bit 1 are set, and the wire stays released.
- R8: Status bits 2 and 3 are cleared by writing 0 to them at address 2. Writing 1 to them leaves them unchanged.
- R9: A control write (address 1) is discarded, leaving the register unchanged, in two cases when self-test (bit 2) is clear in the written value. The first is a write that sets both transmit enable (bit 0) and receive enable (bit 1). The second is a write that sets one enable while only the other is currently set.
- R10: While smart card mode (control bit 3) or transmit enable is clear, the wire is never driven and a written character stays held. No frame starts.
- R11: After reset, control is 0, status reads 0x03 (holding empty, transmit end), the retry limit reads 3, `line_oe` is 0 and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_tick | input | 1 | Strobe at twice the bit rate, one clock wide |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 data, 1 control, 2 status, 3 retry limit |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` |
| line_in | input | 1 | Level seen on the shared data wire |
| line_oe | output | 1 | Pull the data wire low when 1, release when 0 |
| irq_err | output | 1 | Error-signal interrupt request |
| irq_end | output | 1 | Transmit-end interrupt request |

## Verification
The frame path is driven with a table of characters that includes all zeros, all ones, a single set bit and mixed patterns. Each is sent in both normal and inverted order. Together they separate wrong bit order, missing inversion and wrong parity sense. Rejection is produced by the bench pulling the wire low on the sample tick. One run accepts the first resend and so checks that the resend repeats the same frame. Another is rejected past a limit of one and so checks the stop point of the retry count. The enable rule and the gating by mode are checked by reading the control register back and by watching that the wire stays released.

// File: rtl/sc_tx_pkg.sv
`timescale 1ns/1ps
package sc_tx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT_ES, ST_GUARD} tx_state_e;

  localparam logic [1:0] ADDR_DATA  = 2'd0;
  localparam logic [1:0] ADDR_CTRL  = 2'd1;
  localparam logic [1:0] ADDR_STAT  = 2'd2;
  localparam logic [1:0] ADDR_RETRY = 2'd3;

  localparam int CTRL_W    = 7;
  localparam int STAT_ERR  = 2;
  localparam int STAT_OVF  = 3;

  typedef struct packed {
    logic end_ie;
    logic err_ie;
    logic invert;
    logic card_mode;
    logic self_test;
    logic rx_en;
    logic tx_en;
  } ctrl_t;
endpackage

// File: rtl/sc_tx_regs.sv
`timescale 1ns/1ps
module sc_tx_regs
  import sc_tx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int RETRY_W   = 4,
  parameter int DEF_RETRY = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic               load_fresh,
  input  logic               set_err,
  input  logic               set_end,
  input  logic               set_ovf,
  output ctrl_t              ctrl_q,
  output logic [DATA_W-1:0]  hold_q,
  output logic               hold_full_q,
  output logic [RETRY_W-1:0] retry_lim_q,
  output logic               tx_end_q,
  output logic               err_sig_q,
  output logic               retry_ovf_q
);
  ctrl_t              ctrl_d, ctrl_w;
  logic [DATA_W-1:0]  hold_d;
  logic               hold_full_d, tx_end_d, err_sig_d, retry_ovf_d;
  logic [RETRY_W-1:0] retry_lim_d;
  logic               wr_data, wr_ctrl, wr_stat, wr_retry;
  logic               both_bad, swap_bad;

  assign wr_data  = reg_wr && (reg_addr == ADDR_DATA);
  assign wr_ctrl  = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_stat  = reg_wr && (reg_addr == ADDR_STAT);
  assign wr_retry = reg_wr && (reg_addr == ADDR_RETRY);
  assign ctrl_w   = ctrl_t'(reg_wdata[CTRL_W-1:0]);

  // direction guard: no dual enable, no direct swap, unless self-test
  assign both_bad = ctrl_w.tx_en && ctrl_w.rx_en && !ctrl_w.self_test;
  assign swap_bad = !ctrl_w.self_test &&
                    ((ctrl_w.tx_en && ctrl_q.rx_en && !ctrl_q.tx_en) ||
                     (ctrl_w.rx_en && ctrl_q.tx_en && !ctrl_q.rx_en));

  always_comb begin
    ctrl_d      = ctrl_q;
    hold_d      = hold_q;
    hold_full_d = hold_full_q;
    retry_lim_d = retry_lim_q;
    tx_end_d    = tx_end_q;
    err_sig_d   = err_sig_q;
    retry_ovf_d = retry_ovf_q;
    if (wr_ctrl && !both_bad && !swap_bad) ctrl_d = ctrl_w;
    if (wr_retry) retry_lim_d = reg_wdata[RETRY_W-1:0];
    if (load_fresh) begin
      hold_full_d = 1'b0;
      tx_end_d    = 1'b0;
    end
    if (wr_data) begin
      hold_d      = reg_wdata;
      hold_full_d = 1'b1;
    end
    if (wr_stat && !reg_wdata[STAT_ERR]) err_sig_d   = 1'b0;
    if (wr_stat && !reg_wdata[STAT_OVF]) retry_ovf_d = 1'b0;
    if (set_err) err_sig_d   = 1'b1;
    if (set_ovf) retry_ovf_d = 1'b1;
    if (set_end) tx_end_d    = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      retry_lim_q <= RETRY_W'(DEF_RETRY);
      tx_end_q    <= 1'b1;
      err_sig_q   <= 1'b0;
      retry_ovf_q <= 1'b0;
    end else begin
      ctrl_q      <= ctrl_d;
      hold_q      <= hold_d;
      hold_full_q <= hold_full_d;
      retry_lim_q <= retry_lim_d;
      tx_end_q    <= tx_end_d;
      err_sig_q   <= err_sig_d;
      retry_ovf_q <= retry_ovf_d;
    end
  end

  always_comb begin
    unique case (reg_addr)
      ADDR_DATA:  reg_rdata = hold_q;
      ADDR_CTRL:  reg_rdata = DATA_W'(ctrl_q);
      ADDR_STAT:  reg_rdata = DATA_W'({retry_ovf_q, err_sig_q, tx_end_q, !hold_full_q});
      default:    reg_rdata = DATA_W'(retry_lim_q);
    endcase
  end
endmodule

// File: rtl/sc_tx_frame.sv
`timescale 1ns/1ps
module sc_tx_frame #(
  parameter int DATA_W  = 8,
  localparam int FRAME_W = DATA_W + 2
) (
  input  logic [DATA_W-1:0]  data,
  input  logic               invert,
  output logic [FRAME_W-1:0] frame
);
  logic [DATA_W-1:0] wire_bits;

  // wire_bits[i] is the i-th data bit put on the wire
  for (genvar i = 0; i < DATA_W; i++) begin : g_order
    assign wire_bits[i] = invert ? !data[DATA_W-1-i] : data[i];
  end

  assign frame = {^wire_bits, wire_bits, 1'b0};
endmodule

// File: rtl/sc_tx_seq.sv
`timescale 1ns/1ps
module sc_tx_seq
  import sc_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int RETRY_W    = 4,
  parameter int ES_HALF    = 3,
  parameter int GUARD_HALF = 4,
  localparam int FRAME_W   = DATA_W + 2,
  localparam int CNT_W     = $clog2(2 * FRAME_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               half_tick,
  input  logic               run,
  input  logic               hold_full,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [RETRY_W-1:0] retry_lim,
  input  logic               line_in,
  output logic               line_oe,
  output logic               load_fresh,
  output logic               set_err,
  output logic               set_end,
  output logic               set_ovf
);
  localparam logic [CNT_W-1:0] LAST_HALF = CNT_W'(2 * FRAME_W - 1);
  localparam logic [CNT_W-1:0] ES_LAST   = CNT_W'(ES_HALF - 1);
  localparam logic [CNT_W-1:0] GD_LAST   = CNT_W'(GUARD_HALF - 1);

  tx_state_e          state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FRAME_W-1:0] shift_q, shift_d;
  logic [RETRY_W-1:0] tries_q, tries_d;
  logic [CNT_W-2:0]   bit_idx;

  assign bit_idx = cnt_q[CNT_W-1:1];
  assign line_oe = run && (state_q == ST_SEND) && !shift_q[bit_idx];

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    shift_d    = shift_q;
    tries_d    = tries_q;
    load_fresh = 1'b0;
    set_err    = 1'b0;
    set_end    = 1'b0;
    set_ovf    = 1'b0;
    if (!run) begin
      state_d = ST_IDLE;
    end else if (half_tick) begin
      unique case (state_q)
        ST_IDLE: if (hold_full) begin
          state_d    = ST_SEND;
          cnt_d      = '0;
          shift_d    = frame_in;
          tries_d    = '0;
          load_fresh = 1'b1;
        end
        ST_SEND: if (cnt_q == LAST_HALF) begin
          state_d = ST_WAIT_ES;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
        ST_WAIT_ES: if (cnt_q == ES_LAST) begin
          if (!line_in) begin
            set_err = 1'b1;
            if (tries_q == retry_lim) begin
              set_ovf = 1'b1;
              set_end = 1'b1;
              state_d = ST_IDLE;
            end else begin
              tries_d = tries_q + 1'b1;
              state_d = ST_GUARD;
              cnt_d   = '0;
            end
          end else begin
            set_end = 1'b1;
            state_d = ST_IDLE;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
        default: if (cnt_q == GD_LAST) begin
          state_d = ST_SEND;
          cnt_d   = '0;
          shift_d = frame_in;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shift_q <= '1;
      tries_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shift_q <= shift_d;
      tries_q <= tries_d;
    end
  end
endmodule

// File: rtl/sc_char_tx.sv
`timescale 1ns/1ps
module sc_char_tx
  import sc_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int RETRY_W    = 4,
  parameter int DEF_RETRY  = 3,
  parameter int ES_HALF    = 3,
  parameter int GUARD_HALF = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_tick,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              line_in,
  output logic              line_oe,
  output logic              irq_err,
  output logic              irq_end
);
  localparam int FRAME_W = DATA_W + 2;

  ctrl_t              ctrl_q;
  logic [DATA_W-1:0]  hold_q;
  logic               hold_full_q, tx_end_q, err_sig_q, retry_ovf_q;
  logic [RETRY_W-1:0] retry_lim_q;
  logic               load_fresh, set_err, set_end, set_ovf, run;
  logic [FRAME_W-1:0] frame;

  assign run     = ctrl_q.tx_en && ctrl_q.card_mode;
  assign irq_err = err_sig_q && ctrl_q.err_ie;
  assign irq_end = tx_end_q && ctrl_q.end_ie;

  sc_tx_regs #(.DATA_W(DATA_W), .RETRY_W(RETRY_W), .DEF_RETRY(DEF_RETRY)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .load_fresh(load_fresh),
    .set_err(set_err), .set_end(set_end), .set_ovf(set_ovf), .ctrl_q(ctrl_q),
    .hold_q(hold_q), .hold_full_q(hold_full_q), .retry_lim_q(retry_lim_q),
    .tx_end_q(tx_end_q), .err_sig_q(err_sig_q), .retry_ovf_q(retry_ovf_q)
  );

  sc_tx_frame #(.DATA_W(DATA_W)) u_frame (
    .data(hold_q), .invert(ctrl_q.invert), .frame(frame)
  );

  sc_tx_seq #(.DATA_W(DATA_W), .RETRY_W(RETRY_W), .ES_HALF(ES_HALF),
              .GUARD_HALF(GUARD_HALF)) u_seq (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .run(run),
    .hold_full(hold_full_q), .frame_in(frame), .retry_lim(retry_lim_q),
    .line_in(line_in), .line_oe(line_oe), .load_fresh(load_fresh),
    .set_err(set_err), .set_end(set_end), .set_ovf(set_ovf)
  );
endmodule

// File: rtl/sc_char_tx_chk.sv
`timescale 1ns/1ps
module sc_char_tx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [6:0]        ctrl,
  input logic              load_fresh,
  input logic              set_err,
  input logic              set_ovf,
  input logic              hold_full,
  input logic              tx_end,
  input logic              err_sig,
  input logic              retry_ovf,
  input logic              line_oe,
  input logic              irq_err
);
  a_r1_start_driven: assert property (@(posedge clk) disable iff (!rst_n)
    load_fresh && !reg_wr |=> line_oe);

  a_r3_no_end_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    set_err && !set_ovf |=> !tx_end);

  a_r4_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> err_sig && ctrl[5]);

  a_r6_consume_held: assert property (@(posedge clk) disable iff (!rst_n)
    load_fresh |-> hold_full);

  a_r7_ovf_ends: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(retry_ovf) |-> tx_end && !line_oe);

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_sig && !(reg_wr && reg_addr == 2'd2 && !reg_wdata[2]) |=> err_sig);

  a_r9_no_dual_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[0] && ctrl[1] |-> ctrl[2]);

  a_r10_gated_line: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl[0] && ctrl[3]) |-> !line_oe);
endmodule

bind sc_char_tx sc_char_tx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .ctrl(ctrl_q), .load_fresh(load_fresh),
  .set_err(set_err), .set_ovf(set_ovf), .hold_full(hold_full_q),
  .tx_end(tx_end_q), .err_sig(err_sig_q), .retry_ovf(retry_ovf_q),
  .line_oe(line_oe), .irq_err(irq_err)
);

// File: tb/sc_char_tx_tb.sv
`timescale 1ns/1ps
module sc_char_tx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       line_oe, irq_err, irq_end, line_in, half_tick;
  logic       err_drive = 1'b0;
  logic [1:0] tdiv;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tdiv <= '0; else tdiv <= tdiv + 1'b1;
  assign half_tick = &tdiv;
  assign line_in   = !(line_oe || err_drive);

  sc_char_tx u_dut (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .line_in(line_in), .line_oe(line_oe), .irq_err(irq_err), .irq_end(irq_end)
  );

  // {invert, data}
  localparam logic [8:0] VEC [8] = '{
    {1'b0, 8'hA5}, {1'b0, 8'h00}, {1'b0, 8'hFF}, {1'b0, 8'h01},
    {1'b1, 8'h01}, {1'b1, 8'h3C}, {1'b1, 8'hF0}, {1'b0, 8'h96}
  };

  function automatic logic [9:0] exp_frame(input logic [7:0] d, input logic inv);
    logic [9:0] f;
    f[0] = 1'b0;
    for (int i = 0; i < 8; i++) f[1+i] = inv ? ~d[7-i] : d[i];
    f[9] = ^f[8:1];
    return f;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic wait_tick();
    do @(posedge clk); while (half_tick !== 1'b1);
    #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) wait_tick();
  endtask

  // called just after the load tick
  task automatic capture(output logic [9:0] f);
    f[0] = line_in;
    for (int k = 1; k < 10; k++) begin
      ticks(2);
      f[k] = line_in;
    end
  endtask

  // after capture: 4 ticks, then pull low across the sample tick
  task automatic reject();
    ticks(4);
    err_drive = 1'b1;
    wait_tick();
    err_drive = 1'b0;
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [9:0] f1, f2, fe;
    bit         quiet;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11 reset state
    rd(2'd2, r); chk(r == 8'h03, "R11 status", r, 8'h03);
    rd(2'd1, r); chk(r == 8'h00, "R11 ctrl", r, 8'h00);
    rd(2'd3, r); chk(r == 8'h03, "R11 retry", r, 8'h03);
    chk(!line_oe && !irq_err && !irq_end, "R11 outputs",
        {line_oe, irq_err, irq_end}, 0);

    // R9 enable rule
    wr(2'd1, 8'h09);
    wr(2'd1, 8'h0B); rd(2'd1, r); chk(r == 8'h09, "R9 dual", r, 8'h09);
    wr(2'd1, 8'h0A); rd(2'd1, r); chk(r == 8'h09, "R9 swap", r, 8'h09);
    wr(2'd1, 8'h08); wr(2'd1, 8'h0A); rd(2'd1, r); chk(r == 8'h0A, "R9 cleared", r, 8'h0A);
    wr(2'd1, 8'h0F); rd(2'd1, r); chk(r == 8'h0F, "R9 selftest", r, 8'h0F);
    wr(2'd1, 8'h08);

    // R1 R2 R6: vector table
    foreach (VEC[i]) begin
      wr(2'd1, {1'b0, 1'b1, 1'b0, VEC[i][8], 4'b1001});
      wr(2'd0, VEC[i][7:0]);
      wait_tick();
      rd(2'd2, r);
      chk(r[1:0] == 2'b01, "R6 end cleared on load", r, 8'h01);
      chk(!irq_end, "R6 irq_end low", irq_end, 0);
      capture(f1);
      fe = exp_frame(VEC[i][7:0], VEC[i][8]);
      chk(f1 == fe, VEC[i][8] ? "R2 inverted frame" : "R1 frame", f1, fe);
      ticks(5);
      rd(2'd2, r);
      chk(r == 8'h03, "R6 end set", r, 8'h03);
      chk(irq_end, "R6 irq_end", irq_end, 1);
    end

    // R3 R4 R5 R8: one rejection, then accepted resend
    wr(2'd1, 8'h29);
    wr(2'd0, 8'h5A);
    wait_tick();
    capture(f1);
    reject();
    rd(2'd2, r);
    chk(r[2] == 1'b1, "R3 err flag", r, 8'h05);
    chk(r[1] == 1'b0, "R3 end stays clear", r, 8'h05);
    chk(irq_err, "R4 irq_err", irq_err, 1);
    ticks(4);
    capture(f2);
    chk(f2 == f1, "R5 resend same", f2, f1);
    chk(f1 == exp_frame(8'h5A, 1'b0), "R1 frame 5A", f1, exp_frame(8'h5A, 1'b0));
    ticks(5);
    rd(2'd2, r); chk(r == 8'h07, "R6 end after resend", r, 8'h07);
    wr(2'd2, 8'h0C); rd(2'd2, r); chk(r == 8'h07, "R8 write one no effect", r, 8'h07);
    wr(2'd2, 8'h00); rd(2'd2, r); chk(r == 8'h03, "R8 clear", r, 8'h03);
    chk(!irq_err, "R4 irq_err low", irq_err, 0);

    // R7: limit 1, two rejections
    wr(2'd3, 8'h01);
    wr(2'd0, 8'hC3);
    wait_tick();
    capture(f1);
    reject();
    rd(2'd2, r); chk(r[3:1] == 3'b010, "R7 no overflow yet", r, 8'h05);
    ticks(4);
    capture(f2);
    chk(f2 == f1, "R5 resend C3", f2, f1);
    reject();
    rd(2'd2, r); chk(r == 8'h0F, "R7 overflow", r, 8'h0F);
    quiet = 1'b1;
    for (int i = 0; i < 30; i++) begin
      wait_tick();
      if (line_oe) quiet = 1'b0;
    end
    chk(quiet, "R7 no further resend", quiet, 1);
    wr(2'd2, 8'h00); rd(2'd2, r); chk(r == 8'h03, "R8 clear ovf", r, 8'h03);

    // R10: mode off keeps wire released
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h00);
    quiet = 1'b1;
    for (int i = 0; i < 30; i++) begin
      wait_tick();
      if (line_oe) quiet = 1'b0;
    end
    chk(quiet, "R10 line released", quiet, 1);
    rd(2'd2, r); chk(r[0] == 1'b0, "R10 held", r, 8'h02);
    wr(2'd1, 8'h09);
    wait_tick();
    chk(line_oe, "R10 start after enable", line_oe, 1);
    ticks(23);
    rd(2'd2, r); chk(r == 8'h03, "R6 end after enable", r, 8'h03);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule